// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block derives four divided clocks from one fast reference: three output banks (A, B, C) of four copies each, and a feedback clock. Every bank and the feedback path has its own even-ratio divider, with the ratio picked by a small select code. A rate control sets whether the dividers advance on every reference cycle or on every second one. All logic runs in the reference clock domain. The divided clocks are registered signals and not gated clocks.

An active-high master reset clears every divider and drives all outputs low. It also lowers a per-output enable flag, which stands in for a high-impedance driver. When reset is released, every divider starts a new period on the same advance step, so the rising edges of all banks line up. Select changes are taken up only when the affected divider wraps, which keeps pulses from being cut short. A bank C control can drive copies 2 and 3 as the complement of the bank clock.

Top module: `clkdiv_banks`

## Requirements
- R1: Bank A divides the advance rate by 4, 6, 8 or 12 for select codes 0, 1, 2 and 3.
- R2: Bank B divides the advance rate by 4, 6, 8 or 10 for select codes 0, 1, 2 and 3.
- R3: Bank C divides the advance rate by 2, 4, 6 or 8 for select codes 0, 1, 2 and 3.
- R4: The feedback clock divides the advance rate by 4, 6, 8, 10, 8, 12, 16 or 20 for select codes 0 to 7.
- R5: With `fullRate` high the dividers advance on every reference cycle. With it low they advance on every second cycle, so each ratio is doubled in reference cycles.
- R6: While `rstMaster` is high, every divider is cleared. All clock outputs are 0 and all 13 `outEn` bits are 0 from the edge after reset is sampled.
- R7: With `invC` high, bits 2 and 3 of `bankC` carry the complement of bits 0 and 1, which stay non-inverted. With `invC` low all four bits are equal.
- R8: A select change is applied only when the divider finishes its current period. The period in progress completes with the old ratio.
- R9: Every divided clock has a 50% duty cycle. On the first advance step after reset release, all dividers go high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rstMaster | input | 1 | Active-high master reset; clears dividers and disables outputs |
| fullRate | input | 1 | 1: advance every cycle; 0: advance every second cycle |
| selA | input | 2 | Bank A ratio code |
| selB | input | 2 | Bank B ratio code |
| selC | input | 2 | Bank C ratio code |
| selFb | input | 3 | Feedback ratio code |
| invC | input | 1 | Invert bank C copies 2 and 3 |
| bankA | output | 4 | Bank A clock copies |
| bankB | output | 4 | Bank B clock copies |
| bankC | output | 4 | Bank C clock copies (bits 2 and 3 invertible) |
| fbClk | output | 1 | Feedback clock |
| outEn | output | 13 | Per-output enable flags: bits 3:0 bank A, 7:4 bank B, 11:8 bank C, 12 feedback |

## Verification
The assertions assume that `rstMaster` is a clean synchronous level, sampled on `clk`, and that the select inputs change only between clock edges. The bench changes every input just after a falling edge, so each value is stable across the next rising edge. Random selects, rate changes and inversion changes, with occasional reset pulses, therefore stay within these assumptions. The directed cases measure edge-to-edge periods in reference cycles: the start alignment after reset, the doubled period at half rate, and a select change made mid-period.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef struct packed {
    logic tick;    // dividers advance on this cycle
    logic clear;   // hold dividers in reset
    logic enable;  // outputs driven
  } divStrobe_t;

  localparam int unsigned NUM_DIV = 4;

  function automatic int unsigned ratioOfA(input logic [1:0] code);
    case (code)
      2'd0: return 4;
      2'd1: return 6;
      2'd2: return 8;
      default: return 12;
    endcase
  endfunction

  function automatic int unsigned ratioOfB(input logic [1:0] code);
    case (code)
      2'd0: return 4;
      2'd1: return 6;
      2'd2: return 8;
      default: return 10;
    endcase
  endfunction

  function automatic int unsigned ratioOfC(input logic [1:0] code);
    return 2 * (int'(code) + 1);
  endfunction

  function automatic int unsigned ratioOfFb(input logic [2:0] code);
    case (code)
      3'd0: return 4;
      3'd1: return 6;
      3'd2: return 8;
      3'd3: return 10;
      3'd4: return 8;
      3'd5: return 12;
      3'd6: return 16;
      default: return 20;
    endcase
  endfunction

endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rstMaster,
  input  logic       fullRate,
  output divStrobe_t strobe
);

  logic preTog;
  logic enReg;

  always_ff @(posedge clk) begin
    if (rstMaster) begin
      preTog <= 1'b0;
      enReg  <= 1'b0;
    end else begin
      preTog <= ~preTog;
      enReg  <= 1'b1;
    end
  end

  always_comb begin
    strobe.clear  = rstMaster;
    strobe.tick   = !rstMaster && (fullRate || preTog);
    strobe.enable = enReg;
  end

  // R5: at half rate two advance steps never follow each other
  a_r5_half_rate: assert property (@(posedge clk) disable iff (rstMaster)
    (!fullRate && strobe.tick) |=> (fullRate || !strobe.tick));

  // R6: the enable flag is low on the cycle after reset is seen
  a_r6_enable_off: assert property (@(posedge clk)
    rstMaster |=> !strobe.enable);

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  divStrobe_t       strobe,
  input  logic [CNT_W-1:0] ratioSel,
  output logic             q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ratioReg;
  logic [CNT_W-1:0] nextCnt;
  logic             active;
  logic             wrap;

  always_comb begin
    nextCnt = cnt + ONE;
    wrap    = !active || (cnt == ratioReg - ONE);
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      cnt      <= '0;
      ratioReg <= '0;
      active   <= 1'b0;
      q        <= 1'b0;
    end else if (strobe.tick) begin
      if (wrap) begin
        cnt      <= '0;
        ratioReg <= ratioSel;
        active   <= 1'b1;
        q        <= 1'b1;
      end else begin
        cnt <= nextCnt;
        q   <= (nextCnt < (ratioReg >> 1));
      end
    end
  end

  // R8: the ratio in use is kept until the period completes
  a_r8_ratio_hold: assert property (@(posedge clk) disable iff (strobe.clear)
    (active && !wrap) |=> (ratioReg == $past(ratioReg)));

  // R9: each period starts with the clock high
  a_r9_rise_at_wrap: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.tick && wrap) |=> q);

  // R6: reset clears the divider state
  a_r6_reset_clears: assert property (@(posedge clk)
    strobe.clear |=> (!q && !active));

endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic        clk,
  input  divStrobe_t  strobe,
  input  logic [1:0]  selA,
  input  logic [1:0]  selB,
  input  logic [1:0]  selC,
  input  logic [2:0]  selFb,
  input  logic        invC,
  output logic [3:0]  bankA,
  output logic [3:0]  bankB,
  output logic [3:0]  bankC,
  output logic        fbClk,
  output logic [12:0] outEn
);

  logic [CNT_W-1:0] ratioVec [NUM_DIV];
  logic [NUM_DIV-1:0] qVec;

  always_comb begin
    ratioVec[0] = CNT_W'(ratioOfA(selA));
    ratioVec[1] = CNT_W'(ratioOfB(selB));
    ratioVec[2] = CNT_W'(ratioOfC(selC));
    ratioVec[3] = CNT_W'(ratioOfFb(selFb));
  end

  for (genvar g = 0; g < NUM_DIV; g++) begin : gDiv
    clkdiv_counter #(.CNT_W(CNT_W)) uDiv (
      .clk      (clk),
      .strobe   (strobe),
      .ratioSel (ratioVec[g]),
      .q        (qVec[g])
    );
  end

  logic cInv;
  always_comb begin
    cInv  = qVec[2] ^ invC;
    bankA = strobe.enable ? {4{qVec[0]}} : 4'b0;
    bankB = strobe.enable ? {4{qVec[1]}} : 4'b0;
    bankC = strobe.enable ? {cInv, cInv, qVec[2], qVec[2]} : 4'b0;
    fbClk = strobe.enable & qVec[3];
    outEn = {13{strobe.enable}};
  end

  // R7: inverted copies differ from the plain ones when inversion is on
  a_r7_invert: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.enable && invC) |-> (bankC[2] != bankC[0] && bankC[3] != bankC[1]));

endmodule

// File: rtl/clkdiv_banks.sv
module clkdiv_banks
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic        clk,
  input  logic        rstMaster,
  input  logic        fullRate,
  input  logic [1:0]  selA,
  input  logic [1:0]  selB,
  input  logic [1:0]  selC,
  input  logic [2:0]  selFb,
  input  logic        invC,
  output logic [3:0]  bankA,
  output logic [3:0]  bankB,
  output logic [3:0]  bankC,
  output logic        fbClk,
  output logic [12:0] outEn
);

  divStrobe_t strobe;

  clkdiv_ctrl uCtrl (
    .clk       (clk),
    .rstMaster (rstMaster),
    .fullRate  (fullRate),
    .strobe    (strobe)
  );

  clkdiv_datapath #(.CNT_W(CNT_W)) uPath (
    .clk    (clk),
    .strobe (strobe),
    .selA   (selA),
    .selB   (selB),
    .selC   (selC),
    .selFb  (selFb),
    .invC   (invC),
    .bankA  (bankA),
    .bankB  (bankB),
    .bankC  (bankC),
    .fbClk  (fbClk),
    .outEn  (outEn)
  );

endmodule

// File: tb/clkdiv_banks_test.sv
`timescale 1ns/1ps
module clkdiv_banks_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rstMaster, fullRate, invC;
  logic [1:0] selA, selB, selC;
  logic [2:0] selFb;
  logic [3:0] bankA, bankB, bankC;
  logic fbClk;
  logic [12:0] outEn;

  int checks = 0;
  int failures = 0;
  string tagA = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdiv_banks uut (
    .clk(clk), .rstMaster(rstMaster), .fullRate(fullRate),
    .selA(selA), .selB(selB), .selC(selC), .selFb(selFb), .invC(invC),
    .bankA(bankA), .bankB(bankB), .bankC(bankC), .fbClk(fbClk), .outEn(outEn)
  );

  // expected ratios taken from the requirement tables
  function automatic int expRatio(int k);
    int tA[4] = '{4, 6, 8, 12};
    int tB[4] = '{4, 6, 8, 10};
    int tF[8] = '{4, 6, 8, 10, 8, 12, 16, 20};
    case (k)
      0: return tA[selA];
      1: return tB[selB];
      2: return 2 + 2 * int'(selC);
      default: return tF[selFb];
    endcase
  endfunction

  // reference model of the advance steps and period phases
  int mPos[4];
  int mRat[4];
  bit mRun[4];
  bit mHigh[4];
  bit mPre, mEn;

  always @(posedge clk) begin
    if (rstMaster) begin
      mPre <= 0;
      mEn  <= 0;
      for (int k = 0; k < 4; k++) begin
        mPos[k] <= 0; mRat[k] <= 0; mRun[k] <= 0; mHigh[k] <= 0;
      end
    end else begin
      mPre <= !mPre;
      mEn  <= 1;
      if (fullRate || mPre) begin
        for (int k = 0; k < 4; k++) begin
          if (!mRun[k] || mPos[k] == mRat[k] - 1) begin
            mPos[k] <= 0; mRat[k] <= expRatio(k); mRun[k] <= 1; mHigh[k] <= 1;
          end else begin
            mPos[k]  <= mPos[k] + 1;
            mHigh[k] <= (2 * (mPos[k] + 1)) < mRat[k];
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [3:0] eA, eB, eC;
    logic eF;
    logic [12:0] eEn;
    eA  = mEn ? {4{mHigh[0]}} : 4'b0;
    eB  = mEn ? {4{mHigh[1]}} : 4'b0;
    eC  = mEn ? {mHigh[2] ^ invC, mHigh[2] ^ invC, mHigh[2], mHigh[2]} : 4'b0;
    eF  = mEn & mHigh[3];
    eEn = {13{mEn}};
    check(bankA == eA, tagA, bankA, eA);
    check(bankB == eB, "R2", bankB, eB);
    check(bankC[1:0] == eC[1:0], "R3", bankC, eC);
    check(bankC[3:2] == eC[3:2], "R7", bankC, eC);
    check(fbClk == eF, "R4", fbClk, eF);
    check(outEn == eEn, "R6", outEn, eEn);
  endtask

  // cycles until the next rising edge of the chosen output
  task automatic measureRise(input int which, output int n);
    logic prev, cur;
    prev = (which == 0) ? bankA[0] : bankC[0];
    n = 0;
    forever begin
      @(negedge clk);
      compareAll();
      n++;
      cur = (which == 0) ? bankA[0] : bankC[0];
      if (!prev && cur) break;
      prev = cur;
      if (n > 100) break;
    end
  endtask

  task automatic runCycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic resetPulse(int n);
    rstMaster = 1;
    runCycles(n);
    rstMaster = 0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_C10C));
    rstMaster = 1; fullRate = 1; invC = 0;
    selA = 0; selB = 0; selC = 0; selFb = 0;
    repeat (3) @(negedge clk);
    // R6: reset state at the ports
    check(bankA == 0 && bankB == 0 && bankC == 0 && fbClk == 0, "R6", {bankA, bankB, bankC}, 0);
    check(outEn == 0, "R6", outEn, 0);

    // R9: common start after release
    selA = 2'd3; selB = 2'd3; selC = 2'd3; selFb = 3'd7;
    rstMaster = 0;
    @(negedge clk);
    check({bankA[0], bankB[0], bankC[0], fbClk} == 4'hF, "R9", {bankA[0], bankB[0], bankC[0], fbClk}, 4'hF);
    compareAll();
    runCycles(60);

    // R5: half rate doubles the bank C divide-by-2 period
    fullRate = 0; selC = 2'd0;
    resetPulse(2);
    measureRise(2, n);
    measureRise(2, n);
    check(n == 4, "R5", n, 4);
    // R9: duty of bank C at half rate, high for 2 cycles
    @(negedge clk); compareAll();
    check(bankC[0] == 1, "R9", bankC[0], 1);
    @(negedge clk); compareAll();
    check(bankC[0] == 0, "R9", bankC[0], 0);

    // R8: select change during a period
    fullRate = 1; selA = 2'd0; tagA = "R8";
    resetPulse(2);
    @(negedge clk); compareAll();
    check(bankA[0] == 1, "R8", bankA[0], 1);
    selA = 2'd3;
    measureRise(0, n);
    check(n == 4, "R8", n, 4);
    measureRise(0, n);
    check(n == 12, "R8", n, 12);
    tagA = "R1";

    // R7: inversion on directed
    invC = 1; selC = 2'd1;
    runCycles(20);

    // random phase
    for (int it = 0; it < 80; it++) begin
      selA = 2'($urandom); selB = 2'($urandom); selC = 2'($urandom);
      selFb = 3'($urandom); fullRate = 1'($urandom); invC = 1'($urandom);
      if (it % 16 == 15) resetPulse(1 + int'($urandom % 3));
      runCycles(20 + int'($urandom % 30));
    end

    finishRun();
  end

endmodule